// File: doc/BRIEF.md
# Ratio-Guarded Power-of-Two Clock Enable Generator

This block holds the divider setting for six clock domains that all run from one parent clock. Each domain slows the parent by a power of two chosen by a 2-bit exponent. Software writes a 16-bit word through a one-cycle write strobe. Before the word is stored, a combinational guard rewrites the exponent fields so that the ratios between domains obey a fixed set of ordering rules. Read-back returns the word as it was stored after that rewrite.

A free-running counter, shared by all domains, produces one clock-enable pulse per domain. A stored setting is first held as pending. It reaches the pulse generator only when the counter wraps, so every domain's period in progress finishes at its old length. The block does not program a PLL and does not check any upper frequency limit.

Top module: `clkdiv_ratio_guard`

## Requirements
- R1: The enable output for domain d (bit order PER=0, LCD=1, ARM=2, DSP=3, TC=4, MMU=5) is a one-cycle pulse every 2^e parent cycles, where e is the domain's active exponent. With e=0 it is high every cycle.
- R2: The stored MMU exponent is never below the stored DSP exponent and never more than one above it. A value below is raised to DSP; a value too far above is lowered to DSP+1.
- R3: The MMU clamp is applied first. The stored TC exponent is then at least the ARM exponent and at least the already clamped MMU exponent.
- R4: The stored LCD and PER exponents are each at least the final TC exponent.
- R5: Bits [15:12] of a written word are stored unchanged. A word that already meets R2 to R4 reads back exactly as written. Read-back shows the stored word on the cycle after the write.
- R6: A stored word changes the enable pattern only at a counter wrap: the counter runs from 0 to 7, and the new exponents take effect at count 0. At count 0 every enable is high.
- R7: Synchronous active-high reset clears the stored word and the active word to zero and the counter to zero, so after reset every enable is high on every cycle.
- R8: Default field positions: PER [1:0], LCD [3:2], ARM [5:4], DSP [7:6], TC [9:8], MMU [11:10]. Each position is a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the divider word |
| wr_data | input | 16 | Raw divider word from software |
| rd_data | output | 16 | Stored word after the ratio guard |
| dom_en | output | 6 | Per-domain clock-enable pulses |

## Verification
The bench writes words in which a single violation forces a chain of rewrites. One case raises DSP only: MMU, TC, LCD and PER must all follow it. A guard that applied its clamps out of order, or checked TC against the raw MMU value, would leave TC or the slow domains too fast. The bench also covers both MMU bounds, from below and from above. A design that only raised MMU would store a ratio that is too wide. Legal words and the untouched upper nibble confirm that the guard leaves alone what is already legal. Pulse counts over whole counter periods, together with a write placed right after a wrap, catch two faults. A design that switched at once would show a truncated period, and a wrong field position would put the pulses on the wrong domain.

// File: rtl/divguard_pkg.sv
package divguard_pkg;
  localparam int NDOM   = 6;
  localparam int EXP_W  = 2;
  localparam int WORD_W = 16;
  localparam int CNT_W  = (1 << EXP_W) - 1;
  localparam int OFS_W  = 4;

  typedef enum int {D_PER = 0, D_LCD = 1, D_ARM = 2, D_DSP = 3, D_TC = 4, D_MMU = 5} dom_e;
  typedef logic [EXP_W-1:0] exp_t;
  typedef exp_t [NDOM-1:0] exp_vec_t;

  // Ordered ratio rules: MMU vs DSP, then TC vs ARM and MMU, then LCD/PER vs TC
  function automatic exp_vec_t apply_order(exp_vec_t e);
    exp_vec_t r;
    r = e;
    if (r[D_MMU] < r[D_DSP]) r[D_MMU] = r[D_DSP];
    if ({1'b0, r[D_MMU]} > ({1'b0, r[D_DSP]} + 3'd1)) r[D_MMU] = r[D_DSP] + 2'd1;
    if (r[D_TC] < r[D_ARM]) r[D_TC] = r[D_ARM];
    if (r[D_TC] < r[D_MMU]) r[D_TC] = r[D_MMU];
    if (r[D_LCD] < r[D_TC]) r[D_LCD] = r[D_TC];
    if (r[D_PER] < r[D_TC]) r[D_PER] = r[D_TC];
    return r;
  endfunction

  // Counter bits that must be zero for a pulse at exponent e
  function automatic logic [CNT_W-1:0] period_mask(exp_t e);
    return CNT_W'((32'd1 << e) - 32'd1);
  endfunction
endpackage

// File: rtl/divguard_clamp.sv
module divguard_clamp
  import divguard_pkg::*;
#(
  parameter logic [NDOM*OFS_W-1:0] FIELD_OFS = {4'd10, 4'd8, 4'd6, 4'd4, 4'd2, 4'd0},
  parameter int KEEP_LSB = 12
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  exp_vec_t raw_exp;
  exp_vec_t fixed_exp;

  for (genvar d = 0; d < NDOM; d++) begin : g_unpack
    assign raw_exp[d] = word_i[FIELD_OFS[d*OFS_W +: OFS_W] +: EXP_W];
  end

  assign fixed_exp = apply_order(raw_exp);

  always_comb begin
    word_o = '0;
    word_o[WORD_W-1:KEEP_LSB] = word_i[WORD_W-1:KEEP_LSB];
    for (int d = 0; d < NDOM; d++) begin
      word_o[FIELD_OFS[d*OFS_W +: OFS_W] +: EXP_W] = fixed_exp[d];
    end
  end
endmodule

// File: rtl/divguard_regs.sv
module divguard_regs
  import divguard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wrap_i,
  output logic [WORD_W-1:0] staged_o,
  output logic [WORD_W-1:0] active_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      staged_o <= '0;
      active_o <= '0;
    end else begin
      if (wr_en) staged_o <= wr_word;
      if (wrap_i) active_o <= wr_en ? wr_word : staged_o;
    end
  end

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_o) |-> $past(wrap_i));
endmodule

// File: rtl/divguard_pulse.sv
module divguard_pulse
  import divguard_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  exp_vec_t        exp_i,
  output logic            wrap_o,
  output logic [NDOM-1:0] en_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_W'(1);
  end

  assign wrap_o = &cnt;

  for (genvar d = 0; d < NDOM; d++) begin : g_en
    assign en_o[d] = (cnt & period_mask(exp_i[d])) == '0;

    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      (en_o[d] && exp_i[d] != '0) |=> !en_o[d]);
  end

  // R6
  wrap_align_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (&en_o));
endmodule

// File: rtl/clkdiv_ratio_guard.sv
module clkdiv_ratio_guard
  import divguard_pkg::*;
#(
  parameter logic [NDOM*OFS_W-1:0] FIELD_OFS = {4'd10, 4'd8, 4'd6, 4'd4, 4'd2, 4'd0},
  parameter int KEEP_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [NDOM-1:0]   dom_en
);
  logic [WORD_W-1:0] guarded_word;
  logic [WORD_W-1:0] active_word;
  logic              cnt_wrap;
  exp_vec_t          active_exp;
  exp_vec_t          stored_exp;

  divguard_clamp #(.FIELD_OFS(FIELD_OFS), .KEEP_LSB(KEEP_LSB)) u_clamp (
    .word_i (wr_data),
    .word_o (guarded_word)
  );

  divguard_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_word  (guarded_word),
    .wrap_i   (cnt_wrap),
    .staged_o (rd_data),
    .active_o (active_word)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dec
    assign active_exp[d] = active_word[FIELD_OFS[d*OFS_W +: OFS_W] +: EXP_W];
    assign stored_exp[d] = rd_data[FIELD_OFS[d*OFS_W +: OFS_W] +: EXP_W];
  end

  divguard_pulse u_pulse (
    .clk    (clk),
    .rst    (rst),
    .exp_i  (active_exp),
    .wrap_o (cnt_wrap),
    .en_o   (dom_en)
  );

  // R2
  mmu_band_chk: assert property (@(posedge clk) disable iff (rst)
    (stored_exp[D_MMU] >= stored_exp[D_DSP]) &&
    ({1'b0, stored_exp[D_MMU]} <= {1'b0, stored_exp[D_DSP]} + 3'd1));

  // R3
  tc_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (stored_exp[D_TC] >= stored_exp[D_ARM]) && (stored_exp[D_TC] >= stored_exp[D_MMU]));

  // R4
  slow_side_chk: assert property (@(posedge clk) disable iff (rst)
    (stored_exp[D_LCD] >= stored_exp[D_TC]) && (stored_exp[D_PER] >= stored_exp[D_TC]));

  // R5
  nibble_pass_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[WORD_W-1:KEEP_LSB] == $past(wr_data[WORD_W-1:KEEP_LSB]));
endmodule

// File: tb/sim_clkdiv_ratio_guard.sv
`timescale 1ns/1ps
module sim_clkdiv_ratio_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [5:0]  dom_en;
  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkdiv_ratio_guard u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dom_en(dom_en)
  );

  function automatic int unsigned hi(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Independent restatement of R2..R5 with default positions (R8)
  function automatic logic [15:0] guard_model(logic [15:0] w);
    int unsigned p, l, a, d, t, m;
    p = w[1:0]; l = w[3:2]; a = w[5:4]; d = w[7:6]; t = w[9:8]; m = w[11:10];
    if (m < d) m = d;
    if (m > d + 1) m = d + 1;
    t = hi(hi(t, a), m);
    l = hi(l, t);
    p = hi(p, t);
    return {w[15:12], m[1:0], t[1:0], d[1:0], a[1:0], l[1:0], p[1:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    // R7: cleared word, every enable high each cycle
    chk(rd_data == 16'h0, "R7 readback", rd_data, 0);
    for (int i = 0; i < 3; i++) begin
      chk(dom_en == 6'h3f, "R7 enables", dom_en, 6'h3f);
      @(negedge clk);
    end
  endtask

  task automatic t_guard(input logic [15:0] w, input string req);
    logic [15:0] e;
    e = guard_model(w);
    do_write(w);
    chk(rd_data == e, req, rd_data, e);
  endtask

  task automatic t_pulses(input logic [15:0] w);
    logic [15:0] e;
    int cnt [6];
    e = guard_model(w);
    do_write(w);
    repeat (10) @(negedge clk);
    for (int d = 0; d < 6; d++) cnt[d] = 0;
    for (int i = 0; i < 16; i++) begin
      for (int d = 0; d < 6; d++) if (dom_en[d]) cnt[d]++;
      @(negedge clk);
    end
    for (int d = 0; d < 6; d++) begin
      int ex;
      ex = 16 >> e[2*d +: 2];
      chk(cnt[d] == ex, "R1/R8 pulse count", cnt[d], ex);
    end
  endtask

  task automatic t_wrap();
    int guard_n;
    do_write(16'h0FFF);
    repeat (10) @(negedge clk);
    guard_n = 0;
    while (!dom_en[0] && guard_n < 20) begin
      @(negedge clk);
      guard_n++;
    end
    // counter now 0; write all-zero exponents at the next edge
    wr_en = 1'b1; wr_data = 16'h0000;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    // R6: old setting holds for counts 1..7
    for (int i = 0; i < 7; i++) begin
      chk(dom_en == 6'h00, "R6 hold until wrap", dom_en, 0);
      @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      chk(dom_en == 6'h3f, "R6 new after wrap", dom_en, 6'h3f);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_guard(16'hA080, "R2 mmu raised to dsp");
    t_guard(16'h0C00, "R2 mmu lowered to dsp+1");
    t_guard(16'h0030, "R3 tc follows arm, R4 lcd/per follow");
    t_guard(16'h00C0, "R3 cascade from dsp via mmu");
    t_guard(16'h0600, "R4 slow side raised to tc");
    t_guard(16'h5A4B, "R5 legal word unchanged");
    t_guard(16'hFFFF, "R5 all ones unchanged");
    t_pulses(16'h5A4B);
    t_pulses(16'h0E5B);
    t_pulses(16'h0000);
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule